// File: doc/BRIEF.md
# Edge-Counted Delayed Gate Pulser

The block launches a single timed pulse on a power-switch gate, placed relative to traffic seen on an asynchronous serial line. Once armed, it counts rising transitions of the line. When the programmed number of rises has been seen, it waits a programmed number of clock cycles. It then drives the gate high for a programmed number of cycles. The block does not decode bytes. A known command is recognised by how many rising edges its framed bits produce. For example, a 0x11 byte followed by a 0xEE byte in 8N1 framing yields five rises.

Each attempt is one-shot. Raising `arm` starts the count. After the pulse the block parks until `arm` is dropped, so a fresh rising `arm` is needed for the next attempt. Dropping `arm` at any point aborts the attempt and forces the gate low. With a 200 MHz clock, one delay step is 5 ns, so a delay setting of 1790 places the pulse about 8.95 µs after the trigger edge, and a width of 300 gives a 1.5 µs pulse. All ports are plain control and status pins; no data stream enters or leaves the block.

Top module: `edge_sync_pulser`

## Requirements
- R1: While reset is asserted and after it is released with `arm` low, `gate`, `busy` and `fired` are all 0.
- R2: `busy` goes high on the clock edge that first samples `arm` high and stays high until the edge on which `gate` returns low. `gate` is never high while `busy` is low.
- R3: In the counting phase, only rising transitions of `rx_line` are counted, after a two-flop synchroniser. Rises seen before arming and all falling transitions are ignored. The phase ends on the rise whose number equals `edge_target`, and a target of 0 behaves as 1. Framing is a start bit 0, eight data bits LSB first and a stop bit 1, so 0x11 then 0xEE gives 5 rises.
- R4: `gate` is a registered output. If `rx_line` makes the triggering rise just after rising clock edge p, `gate` is first high after rising edge p+4+`delay_cycles`. This holds for every delay from 0 to 65535, including the 1200 to 2000 sweep range.
- R5: `gate` stays high for exactly `pulse_cycles` clock cycles, and a width of 0 behaves as 1.
- R6: At most one pulse occurs per arm. Line activity after the trigger, while `arm` stays high, produces no further pulse.
- R7: Sampling `arm` low in any state sends the block idle on that edge: `gate` and `busy` are 0 in the next cycle and no pulse follows.
- R8: `fired` rises together with `gate` and then holds. It is cleared only on the edge where a new arm is accepted.
- R9: If fewer rises than `edge_target` arrive, no pulse occurs and `busy` stays high for as long as `arm` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial line (idle high) |
| arm | input | 1 | Level arm; high runs an attempt, low aborts |
| delay_cycles | input | DELAY_W | Cycles from trigger rise to pulse |
| edge_target | input | EDGE_W | Number of rises that ends the count |
| pulse_cycles | input | WIDTH_W | Gate pulse width in cycles |
| gate | output | 1 | Registered gate drive to the power switch |
| busy | output | 1 | Attempt in progress (count, delay or pulse) |
| fired | output | 1 | A pulse was issued for the current arm |

## Verification
The assertions assume the following about the inputs:
- `arm` is a level held for the whole attempt.
- `delay_cycles`, `edge_target` and `pulse_cycles` do not change while `busy` is high.
- `rx_line` holds each level for at least two clock cycles, so the synchroniser never merges two transitions.

The stimulus meets these assumptions in three ways. It writes all settings before raising `arm`. It shapes every serial bit as four clock cycles. It changes `rx_line` only between clock edges.

The random targets sometimes exceed the number of rises in the frames. This exercises the path where the block waits without firing.

// File: rtl/pulser_pkg.sv
package pulser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_DELAY,
    ST_PULSE,
    ST_DONE
  } pulser_state_t;
endpackage

// File: rtl/rx_edge_detect.sv
module rx_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic rise
);
  // chain[0..STAGES-1]: synchroniser, chain[STAGES]: previous synced sample
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], line_async};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/span_timer.sv
module span_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - W'(1);
  end

  assign expired = (count == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);  // R5
endmodule

// File: rtl/edge_sync_pulser.sv
module edge_sync_pulser #(
  parameter int DELAY_W     = 16,
  parameter int WIDTH_W     = 16,
  parameter int EDGE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_line,
  input  logic               arm,
  input  logic [DELAY_W-1:0] delay_cycles,
  input  logic [EDGE_W-1:0]  edge_target,
  input  logic [WIDTH_W-1:0] pulse_cycles,
  output logic               gate,
  output logic               busy,
  output logic               fired
);
  import pulser_pkg::*;

  localparam int TMR_W = (DELAY_W > WIDTH_W) ? DELAY_W : WIDTH_W;

  pulser_state_t     state, nxt;
  logic [EDGE_W-1:0] edge_cnt, cnt_nxt;
  logic [EDGE_W:0]   cnt_plus;
  logic              hit, rise, expired, tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic [WIDTH_W-1:0] width_m1;

  rx_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_async (rx_line),
    .rise       (rise)
  );

  span_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  // target 0 behaves as 1: compare count-after-this-rise against target
  assign cnt_plus = {1'b0, edge_cnt} + (EDGE_W+1)'(1);
  assign hit      = cnt_plus >= {1'b0, edge_target};
  assign width_m1 = (pulse_cycles == '0) ? '0 : pulse_cycles - WIDTH_W'(1);

  always_comb begin
    nxt      = state;
    cnt_nxt  = edge_cnt;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (arm) begin
          nxt     = ST_COUNT;
          cnt_nxt = '0;
        end
      end
      ST_COUNT: begin
        if (rise) begin
          if (hit) begin
            nxt      = ST_DELAY;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(delay_cycles);
          end else begin
            cnt_nxt = edge_cnt + EDGE_W'(1);
          end
        end
      end
      ST_DELAY: begin
        if (expired) begin
          nxt      = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(width_m1);
        end
      end
      ST_PULSE: begin
        if (expired) nxt = ST_DONE;
      end
      default: ;
    endcase
    if (!arm) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      gate     <= 1'b0;
      fired    <= 1'b0;
    end else begin
      state    <= nxt;
      edge_cnt <= cnt_nxt;
      gate     <= (nxt == ST_PULSE);
      if (state == ST_IDLE && nxt == ST_COUNT)
        fired <= 1'b0;
      else if (nxt == ST_PULSE && state != ST_PULSE)
        fired <= 1'b1;
    end
  end

  assign busy = (state == ST_COUNT) || (state == ST_DELAY) || (state == ST_PULSE);

  // pulse tally per arm, for the one-shot check
  logic       gate_q;
  logic [1:0] pulses_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q      <= 1'b0;
      pulses_seen <= '0;
    end else begin
      gate_q <= gate;
      if (!arm)
        pulses_seen <= '0;
      else if (gate && !gate_q && pulses_seen != 2'd3)
        pulses_seen <= pulses_seen + 2'd1;
    end
  end

  AST_GATE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> busy);  // R2
  AST_ONE_PULSE_PER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_seen <= 2'd1);  // R6
  AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!gate && !busy));  // R7
  AST_FIRED_WITH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> fired);  // R8
  AST_FIRED_CLEAR_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !fired);  // R8
endmodule

// File: tb/test_edge_sync_pulser.sv
module test_edge_sync_pulser;
  localparam int BIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic        arm = 1'b0;
  logic [15:0] delay_cycles = '0;
  logic [7:0]  edge_target = 8'd5;
  logic [15:0] pulse_cycles = 16'd1;
  logic        gate, busy, fired;

  always #10 clk = ~clk;  // 50 MHz

  edge_sync_pulser i_edge_sync_pulser (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .arm(arm),
    .delay_cycles(delay_cycles), .edge_target(edge_target),
    .pulse_cycles(pulse_cycles),
    .gate(gate), .busy(busy), .fired(fired)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // gate monitor
  int first_hi = -1, hi_cnt = 0, pulses = 0;
  logic gate_q = 1'b0;
  always @(negedge clk) begin
    if (gate && !gate_q) begin
      pulses++; first_hi = cyc; hi_cnt = 0;
    end
    if (gate) hi_cnt++;
    gate_q = gate;
  end

  // serial driver bookkeeping
  int rises_sent = 0, tgt_eff = 1, last_p = -1;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit v);
    @(negedge clk);
    if (v && !rx_line) begin
      rises_sent++;
      if (rises_sent == tgt_eff) last_p = cyc;
    end
    rx_line = v;
    repeat (BIT-1) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(1'b1);
  endtask

  function automatic int count_rises(input logic [7:0] b0, input logic [7:0] b1);
    logic [19:0] bits;
    logic prev;
    int n;
    bits = {1'b1, b1, 1'b0, 1'b1, b0, 1'b0};
    prev = 1'b1; n = 0;
    for (int i = 0; i < 20; i++) begin
      if (bits[i] && !prev) n++;
      prev = bits[i];
    end
    return n;
  endfunction

  function automatic int exp_first(input int p, input int d);
    return p + 4 + d;
  endfunction

  task automatic attempt(input logic [7:0] b0, input logic [7:0] b1,
                         input int tgt, input int d, input int w);
    bit fire;
    int pl;
    tgt_eff = (tgt == 0) ? 1 : tgt;
    fire = count_rises(b0, b1) >= tgt_eff;
    edge_target = 8'(tgt); delay_cycles = 16'(d); pulse_cycles = 16'(w);
    pulses = 0; first_hi = -1; rises_sent = 0; last_p = -1;
    @(negedge clk); arm = 1'b1;
    @(negedge clk);
    chk("R2 busy after arm", busy, 1);
    chk("R8 fired cleared on arm", fired, 0);
    @(negedge clk);
    send_byte(b0); send_byte(b1);
    repeat (d + w + 20) @(negedge clk);
    if (fire) begin
      chk("R6 single pulse", pulses, 1);
      chk("R4 pulse start cycle", first_hi, exp_first(last_p, d));
      chk("R5 pulse width", hi_cnt, (w == 0) ? 1 : w);
      chk("R2 busy low after pulse", busy, 0);
      chk("R8 fired held", fired, 1);
      pl = pulses;
      send_byte(8'h55);
      repeat (d + w + 10) @(negedge clk);
      chk("R6 no second pulse while armed", pulses, pl);
    end else begin
      chk("R9 no pulse when short of target", pulses, 0);
      chk("R9 busy held when short of target", busy, 1);
    end
    @(negedge clk); arm = 1'b0;
    @(negedge clk);
    chk("R7 busy low after disarm", busy, 0);
    chk("R8 fired kept after disarm", fired, fire ? 1 : 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic abort_case(input int d, input int w, input int wait_c, input bit expect_gate);
    edge_target = 8'd5; delay_cycles = 16'(d); pulse_cycles = 16'(w);
    tgt_eff = 5; pulses = 0; rises_sent = 0;
    @(negedge clk); arm = 1'b1;
    repeat (2) @(negedge clk);
    send_byte(8'h11); send_byte(8'hEE);
    repeat (wait_c) @(negedge clk);
    chk("R7 gate state before abort", gate, expect_gate ? 1 : 0);
    arm = 1'b0;
    @(negedge clk);
    chk("R7 gate low after abort", gate, 0);
    chk("R7 busy low after abort", busy, 0);
    repeat (d + w + 10) @(negedge clk);
    chk("R7 no pulse after abort", pulses, expect_gate ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", gate, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 fired in reset", fired, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 gate after reset", gate, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 fired after reset", fired, 0);

    // R3: rises before arming are ignored
    send_byte(8'h11); send_byte(8'hEE);
    repeat (5) @(negedge clk);
    chk("R3 idle ignores line", busy, 0);

    // directed
    chk("R3 five rises in 0x11 0xEE", count_rises(8'h11, 8'hEE), 5);
    attempt(8'h11, 8'hEE, 5, 20, 12);   // R3 R4 R5 default trigger
    attempt(8'h11, 8'hEE, 5, 1790, 300);// R4 sweep-range delay, R5 default width
    attempt(8'h11, 8'hEE, 5, 1200, 3);  // R4 low end of sweep
    attempt(8'h11, 8'hEE, 5, 0, 0);     // R4 zero delay, R5 zero width
    attempt(8'h11, 8'hEE, 0, 7, 2);     // R3 target 0 acts as 1
    attempt(8'h11, 8'hEE, 6, 5, 5);     // R9 short of target
    abort_case(200, 10, 30, 1'b0);      // R7 abort during delay
    abort_case(0, 200, 20, 1'b1);       // R7 abort during pulse

    // constrained random
    for (int t = 0; t < 24; t++) begin
      logic [7:0] b0, b1;
      int tot;
      b0 = 8'($urandom);
      b1 = 8'($urandom);
      tot = count_rises(b0, b1);
      attempt(b0, b1, $urandom_range(tot + 1, 0),
              $urandom_range(80, 0), $urandom_range(40, 0));
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule